// File: doc/BRIEF.md
# Parallel Port Register-Access Master

This block is the host end of an 8-bit byte-wide parallel link used to reach registers inside a peripheral. A local client hands it one command at a time over a valid/ready handshake: load the peripheral's address register, write a data byte, read a data byte, or perform a complete register read. For each command the block sequences one or two bus cycles. Each cycle drives the direction line, the shared data bus and one of two active-low strobes, and then runs a four-phase handshake against the peripheral's acknowledge line.

The acknowledge line is asynchronous to the block clock, so it passes through a synchronizer before any decision depends on it. A strobe is held low until the synchronized acknowledge is seen high. If the acknowledge never comes, a programmable limit ends the cycle and the command finishes with an error. When a command finishes, the block emits a one-cycle completion pulse. The returned byte and the error flag stay stable from that pulse until the next completion.

Back-pressure works as follows. A command transfers on a clock edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` stays low from that edge until the completion pulse. The completion side cannot be stalled, so a client that needs the result must capture `rsp_data`/`rsp_err` before its next command completes.

Top module: `pport_reg_master`

## Requirements
- R1: Reset state. During and after reset, and until a command is accepted, the outputs are: both strobes high, `pp_write_n` high, `pp_data_oe` low, `cmd_ready` high, `done` low, `rsp_data` 0 and `rsp_err` 0.
- R2: Command code 0 (address load) runs one cycle on the address strobe. During it `pp_write_n` is low and `pp_data_o` carries `cmd_addr`.
- R3: Command code 1 (data write) runs one cycle on the data strobe. During it `pp_write_n` is low and `pp_data_o` carries `cmd_wdata`.
- R4: Command code 2 (data read) runs one cycle on the data strobe with `pp_write_n` high and `pp_data_oe` low. `pp_data_i` is captured on the clock edge where the acknowledge, after a two-flop synchronizer, is first seen high. The captured byte appears on `rsp_data` with the completion pulse.
- R5: Command code 3 (register read) runs an address-load cycle carrying `cmd_addr`, then a data-read cycle, and produces a single completion pulse that returns the byte read.
- R6: `pp_write_n` takes its value at least one clock before a strobe falls and does not change while that strobe is low.
- R7: A strobe stays low until the synchronized acknowledge is high and is then released. No strobe falls while the acknowledge is still high from the previous cycle. At most one strobe is low at a time.
- R8: If the acknowledge is already high when a cycle is ready to start, the peripheral is treated as busy. The strobe is held off until the acknowledge drops, and the command then completes normally.
- R9: If the acknowledge does not rise, the strobe is released after exactly `tmo_limit` clocks low (a limit of 0 behaves as 1). The command then completes with `rsp_err` = 1 and `rsp_data` unchanged. A register read that times out in its address phase issues no data cycle.
- R10: `done` is a single-cycle pulse, one per accepted command. `cmd_ready` is low from acceptance until completion. `rsp_data` and `rsp_err` change only in a cycle where `done` is high, and `rsp_err` is 0 for a command that completes without a timeout.
- R11: `pp_data_oe` is high only during cycles with `pp_write_n` low. The block never drives the bus while `pp_write_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 2 | Command code: 0 address load, 1 data write, 2 data read, 3 register read |
| cmd_addr | input | 8 | Register index for codes 0 and 3 |
| cmd_wdata | input | 8 | Write byte for code 1 |
| tmo_limit | input | 16 | Maximum clocks a strobe waits for the acknowledge |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Last byte read, held between completions |
| rsp_err | output | 1 | Last command timed out, held between completions |
| pp_addr_stb_n | output | 1 | Address strobe, active low |
| pp_data_stb_n | output | 1 | Data strobe, active low |
| pp_write_n | output | 1 | Direction: low host-to-peripheral, high peripheral-to-host |
| pp_ack | input | 1 | Peripheral acknowledge (asynchronous), high when the cycle is taken |
| pp_data_i | input | 8 | Bus value seen at the pins |
| pp_data_o | output | 8 | Bus value to drive |
| pp_data_oe | output | 1 | Enable for the bus driver |

## Verification
The hardest states to reach from the ports are those where the peripheral misbehaves. In one, the acknowledge is already high when a cycle wants to start. In another, it never rises, and the hardest case of that is a register read abandoned in its address phase. The bench peripheral model has knobs for a busy window that holds the acknowledge high ahead of a command, for a dead mode that never answers, and for the response delay. The bench counts strobe widths and data-strobe edges at the pins, so it can show that a timed-out register read never reached its data phase and that the later commands still return the right bytes.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int PP_BUS_W = 8;

  typedef enum logic [1:0] {
    OP_ADDR_WR = 2'd0,
    OP_DATA_WR = 2'd1,
    OP_DATA_RD = 2'd2,
    OP_REG_RD  = 2'd3
  } pp_op_e;

  typedef enum logic [1:0] {
    CY_IDLE,
    CY_SETUP,
    CY_STROBE,
    CY_RELEASE
  } cyc_st_e;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_ISSUE,
    TX_WAIT
  } txn_st_e;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pport_cycle_eng.sv
module pport_cycle_eng
  import pport_pkg::*;
#(
  parameter int DW = PP_BUS_W,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          req_addr,
  input  logic          req_rd,
  input  logic [DW-1:0] req_wdata,
  input  logic [TW-1:0] tmo_limit,
  input  logic          ack_s,
  input  logic [DW-1:0] bus_i,
  output logic          eng_idle,
  output logic          cyc_ok,
  output logic          cyc_tmo,
  output logic [DW-1:0] cyc_rdata,
  output logic          addr_stb_n,
  output logic          data_stb_n,
  output logic          write_n,
  output logic          bus_oe,
  output logic [DW-1:0] bus_o
);
  localparam int CW = TW + 1;

  cyc_st_e       st;
  logic          on_addr;
  logic          rd;
  logic [DW-1:0] wdata;
  logic [TW-1:0] cnt;
  logic [CW-1:0] cnt_next;
  logic          limit_hit;

  assign cnt_next  = {1'b0, cnt} + CW'(1);
  assign limit_hit = cnt_next >= {1'b0, tmo_limit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= CY_IDLE;
      on_addr   <= 1'b0;
      rd        <= 1'b1;
      wdata     <= '0;
      cnt       <= '0;
      cyc_rdata <= '0;
      cyc_ok    <= 1'b0;
      cyc_tmo   <= 1'b0;
    end else begin
      cyc_ok  <= 1'b0;
      cyc_tmo <= 1'b0;
      case (st)
        CY_IDLE: begin
          if (start) begin
            on_addr <= req_addr;
            rd      <= req_rd;
            wdata   <= req_wdata;
            st      <= CY_SETUP;
          end
        end
        CY_SETUP: begin
          if (!ack_s) begin
            cnt <= '0;
            st  <= CY_STROBE;
          end
        end
        CY_STROBE: begin
          if (ack_s) begin
            if (rd) cyc_rdata <= bus_i;
            st <= CY_RELEASE;
          end else if (limit_hit) begin
            cyc_tmo <= 1'b1;
            st      <= CY_IDLE;
          end else begin
            cnt <= cnt_next[TW-1:0];
          end
        end
        CY_RELEASE: begin
          if (!ack_s) begin
            cyc_ok <= 1'b1;
            st     <= CY_IDLE;
          end
        end
        default: st <= CY_IDLE;
      endcase
    end
  end

  assign eng_idle   = (st == CY_IDLE);
  assign addr_stb_n = !((st == CY_STROBE) && on_addr);
  assign data_stb_n = !((st == CY_STROBE) && !on_addr);
  assign write_n    = (st == CY_IDLE) ? 1'b1 : rd;
  assign bus_oe     = (st != CY_IDLE) && !rd;
  assign bus_o      = bus_oe ? wdata : '0;

  p_dir_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(addr_stb_n) || $fell(data_stb_n)) |-> $stable(write_n));

  p_dir_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_stb_n || !data_stb_n) && $past(!addr_stb_n || !data_stb_n) |-> $stable(write_n));

  p_hold_until_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(addr_stb_n) || $rose(data_stb_n)) |-> ($past(ack_s) || cyc_tmo));

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!addr_stb_n && !data_stb_n));

  p_no_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(addr_stb_n) || $fell(data_stb_n)) |-> !$past(ack_s));

  p_tmo_from_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_tmo |-> ($past(st) == CY_STROBE) && !$past(ack_s));

  p_no_drive_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !write_n);
endmodule

// File: rtl/pport_txn_seq.sv
module pport_txn_seq
  import pport_pkg::*;
#(
  parameter int DW = PP_BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic          eng_idle,
  input  logic          cyc_ok,
  input  logic          cyc_tmo,
  input  logic [DW-1:0] cyc_rdata,
  output logic          start,
  output logic          iss_addr,
  output logic          iss_rd,
  output logic [DW-1:0] iss_wdata,
  output logic          done,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err
);
  txn_st_e       st;
  pp_op_e        cur_op;
  logic [DW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;
  logic          in_data;
  logic          final_phase;

  always_comb begin
    iss_addr  = 1'b0;
    iss_rd    = 1'b0;
    iss_wdata = cur_wdata;
    case (cur_op)
      OP_ADDR_WR: begin
        iss_addr  = 1'b1;
        iss_wdata = cur_addr;
      end
      OP_DATA_WR: iss_rd = 1'b0;
      OP_DATA_RD: iss_rd = 1'b1;
      OP_REG_RD: begin
        if (!in_data) begin
          iss_addr  = 1'b1;
          iss_wdata = cur_addr;
        end else begin
          iss_rd = 1'b1;
        end
      end
      default: iss_rd = 1'b0;
    endcase
  end

  assign final_phase = (cur_op != OP_REG_RD) || in_data;
  assign cmd_ready   = (st == TX_IDLE);
  assign start       = (st == TX_ISSUE) && eng_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= TX_IDLE;
      cur_op    <= OP_ADDR_WR;
      cur_addr  <= '0;
      cur_wdata <= '0;
      in_data   <= 1'b0;
      done      <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        TX_IDLE: begin
          if (cmd_valid) begin
            cur_op    <= pp_op_e'(cmd_op);
            cur_addr  <= cmd_addr;
            cur_wdata <= cmd_wdata;
            in_data   <= 1'b0;
            st        <= TX_ISSUE;
          end
        end
        TX_ISSUE: begin
          if (eng_idle) st <= TX_WAIT;
        end
        TX_WAIT: begin
          if (cyc_tmo) begin
            done    <= 1'b1;
            rsp_err <= 1'b1;
            st      <= TX_IDLE;
          end else if (cyc_ok) begin
            if (!final_phase) begin
              in_data <= 1'b1;
              st      <= TX_ISSUE;
            end else begin
              done    <= 1'b1;
              rsp_err <= 1'b0;
              if (iss_rd) rsp_data <= cyc_rdata;
              st      <= TX_IDLE;
            end
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_rsp_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(rsp_data) && $stable(rsp_err)));

  p_ready_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  p_chain_no_data_after_tmo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_tmo && st == TX_WAIT) |=> (st == TX_IDLE));
endmodule

// File: rtl/pport_reg_master.sv
module pport_reg_master
  import pport_pkg::*;
#(
  parameter int DW          = PP_BUS_W,
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [TW-1:0] tmo_limit,
  output logic          done,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  output logic          pp_addr_stb_n,
  output logic          pp_data_stb_n,
  output logic          pp_write_n,
  input  logic          pp_ack,
  input  logic [DW-1:0] pp_data_i,
  output logic [DW-1:0] pp_data_o,
  output logic          pp_data_oe
);
  logic          ack_s;
  logic          eng_idle;
  logic          cyc_ok;
  logic          cyc_tmo;
  logic [DW-1:0] cyc_rdata;
  logic          start;
  logic          iss_addr;
  logic          iss_rd;
  logic [DW-1:0] iss_wdata;

  pport_sync #(.W(1), .STAGES(SYNC_STAGES)) i_ack_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pp_ack),
    .q     (ack_s)
  );

  pport_txn_seq #(.DW(DW)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .eng_idle  (eng_idle),
    .cyc_ok    (cyc_ok),
    .cyc_tmo   (cyc_tmo),
    .cyc_rdata (cyc_rdata),
    .start     (start),
    .iss_addr  (iss_addr),
    .iss_rd    (iss_rd),
    .iss_wdata (iss_wdata),
    .done      (done),
    .rsp_data  (rsp_data),
    .rsp_err   (rsp_err)
  );

  pport_cycle_eng #(.DW(DW), .TW(TW)) i_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .req_addr   (iss_addr),
    .req_rd     (iss_rd),
    .req_wdata  (iss_wdata),
    .tmo_limit  (tmo_limit),
    .ack_s      (ack_s),
    .bus_i      (pp_data_i),
    .eng_idle   (eng_idle),
    .cyc_ok     (cyc_ok),
    .cyc_tmo    (cyc_tmo),
    .cyc_rdata  (cyc_rdata),
    .addr_stb_n (pp_addr_stb_n),
    .data_stb_n (pp_data_stb_n),
    .write_n    (pp_write_n),
    .bus_oe     (pp_data_oe),
    .bus_o      (pp_data_o)
  );
endmodule

// File: tb/test_pport_reg_master.sv
`timescale 1ns/1ps
module test_pport_reg_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic [7:0]  cmd_addr = 8'd0;
  logic [7:0]  cmd_wdata = 8'd0;
  logic [15:0] tmo_limit = 16'd40;
  logic        done;
  logic [7:0]  rsp_data;
  logic        rsp_err;
  logic        pp_addr_stb_n, pp_data_stb_n, pp_write_n;
  logic        pp_ack = 1'b0;
  logic [7:0]  pp_data_i = 8'd0;
  logic [7:0]  pp_data_o;
  logic        pp_data_oe;

  always #2 clk = ~clk;

  pport_reg_master i_pport_reg_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .tmo_limit(tmo_limit),
    .done(done), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .pp_addr_stb_n(pp_addr_stb_n), .pp_data_stb_n(pp_data_stb_n), .pp_write_n(pp_write_n),
    .pp_ack(pp_ack), .pp_data_i(pp_data_i), .pp_data_o(pp_data_o), .pp_data_oe(pp_data_oe)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // peripheral model
  logic [7:0] pm_mem [256];
  logic [7:0] pm_addr = 8'd0;
  int  ps = 0;
  int  dcnt = 0;
  int  resp_delay = 2;
  bit  dead = 1'b0;
  int  busy_cnt = 0;
  bit  pm_drive = 1'b0;
  bit  prev_lo = 1'b0;
  logic prev_wn = 1'b1;
  int  lo_len = 0;
  int  last_len = 0;
  int  dfall = 0;
  logic prev_dstb = 1'b1;
  int  dir_viol = 0;
  int  drive_viol = 0;
  int  ack_viol = 0;
  int  dual_viol = 0;

  always @(negedge clk) begin
    logic lo;
    lo = !pp_addr_stb_n || !pp_data_stb_n;
    if (rst_n) begin
      if (lo && !prev_lo && pp_write_n !== prev_wn) dir_viol++;          // R6
      if (lo && prev_lo && pp_write_n !== prev_wn) dir_viol++;           // R6
      if (pp_data_oe && pp_write_n) drive_viol++;                        // R11
      if (pp_data_oe && pm_drive) drive_viol++;                          // R11
      if (lo && !prev_lo && pp_ack) ack_viol++;                          // R7 R8
      if (!pp_addr_stb_n && !pp_data_stb_n) dual_viol++;                 // R7
      if (!pp_data_stb_n && prev_dstb) dfall++;
      if (lo) lo_len++;
      else if (prev_lo) begin last_len = lo_len; lo_len = 0; end
      case (ps)
        0: begin
          if (busy_cnt > 0) begin pp_ack = 1'b1; busy_cnt--; end
          else pp_ack = 1'b0;
          if (lo && !dead && !pp_ack) begin dcnt = resp_delay; ps = 1; end
        end
        1: begin
          if (!lo) ps = 0;
          else if (dcnt == 0) begin
            if (!pp_addr_stb_n) begin
              if (!pp_write_n) pm_addr = pp_data_o;
            end else if (!pp_write_n) pm_mem[pm_addr] = pp_data_o;
            else begin pp_data_i = pm_mem[pm_addr]; pm_drive = 1'b1; end
            pp_ack = 1'b1;
            ps = 2;
          end else dcnt--;
        end
        default: begin
          if (!lo) begin pp_ack = 1'b0; pm_drive = 1'b0; pp_data_i = 8'd0; ps = 0; end
        end
      endcase
    end
    prev_lo = lo;
    prev_wn = pp_write_n;
    prev_dstb = pp_data_stb_n;
  end

  // scoreboard
  logic [8:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] sh_mem [256];
  logic [7:0] sh_addr = 8'd0;
  logic [7:0] last_rsp = 8'd0;
  bit   prev_done = 1'b0;
  logic [7:0] prev_rd = 8'd0;
  logic prev_re = 1'b0;
  int   pulse_viol = 0;
  int   stable_viol = 0;
  int   orphan = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (exp_q.size() == 0) orphan++;
        else begin
          logic [8:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rsp_err === e[8], t, "rsp_err", int'(rsp_err), int'(e[8]));
          chk(rsp_data === e[7:0], t, "rsp_data", int'(rsp_data), int'(e[7:0]));
        end
        if (prev_done) pulse_viol++;
      end else if (rsp_data !== prev_rd || rsp_err !== prev_re) stable_viol++;
      prev_done = done;
      prev_rd = rsp_data;
      prev_re = rsp_err;
    end
  end

  task automatic run_cmd(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d,
                         input bit tmo, input string tag);
    logic [7:0] e;
    e = last_rsp;
    if (!tmo) begin
      case (op)
        2'd0: sh_addr = a;
        2'd1: sh_mem[sh_addr] = d;
        2'd2: e = sh_mem[sh_addr];
        default: begin sh_addr = a; e = sh_mem[a]; end
      endcase
    end
    last_rsp = e;
    exp_q.push_back({tmo, e});
    tag_q.push_back(tag);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R10", "cmd_ready after accept", int'(cmd_ready), 0);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    int df0;
    for (int i = 0; i < 256; i++) begin
      sh_mem[i] = 8'(i * 7 + 3);
      pm_mem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    // R1 reset state while reset is held and after release
    chk(pp_addr_stb_n && pp_data_stb_n, "R1", "strobes in reset", int'({pp_addr_stb_n, pp_data_stb_n}), 3);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(pp_write_n == 1'b1 && pp_data_oe == 1'b0, "R1", "direction/enable idle", int'({pp_write_n, pp_data_oe}), 2);
    chk(cmd_ready == 1'b1 && done == 1'b0, "R1", "ready/done idle", int'({cmd_ready, done}), 2);
    chk(rsp_data == 8'd0 && rsp_err == 1'b0, "R1", "response idle", int'({rsp_err, rsp_data}), 0);

    run_cmd(2'd0, 8'h10, 8'h00, 1'b0, "R2 address load");
    run_cmd(2'd1, 8'h00, 8'hA5, 1'b0, "R3 data write");
    run_cmd(2'd2, 8'h00, 8'h00, 1'b0, "R4 data read");
    chk(pm_addr == 8'h10, "R2", "peripheral address register", int'(pm_addr), 8'h10);
    run_cmd(2'd3, 8'h00, 8'h00, 1'b0, "R5 register read idx0");
    run_cmd(2'd3, 8'h10, 8'h00, 1'b0, "R5 register read idx10");

    for (int dl = 0; dl < 8; dl += 3) begin
      resp_delay = dl;
      run_cmd(2'd0, 8'(8'h30 + dl), 8'h00, 1'b0, "R2 load delay");
      run_cmd(2'd1, 8'h00, 8'(8'h3C ^ dl), 1'b0, "R3 write delay");
      run_cmd(2'd2, 8'h00, 8'h00, 1'b0, "R4 read delay");
    end
    resp_delay = 2;

    // R8 busy hold-off
    busy_cnt = 12;
    repeat (3) @(negedge clk);
    run_cmd(2'd3, 8'h33, 8'h00, 1'b0, "R8 busy then register read");

    // R9 timeout with write
    tmo_limit = 16'd6;
    dead = 1'b1;
    run_cmd(2'd1, 8'h00, 8'h77, 1'b1, "R9 write timeout");
    chk(last_len == 6, "R9", "strobe low clocks", last_len, 6);
    df0 = dfall;
    run_cmd(2'd3, 8'h44, 8'h00, 1'b1, "R9 register read timeout");
    chk(dfall == df0, "R9", "data strobes after address timeout", dfall - df0, 0);
    tmo_limit = 16'd0;
    run_cmd(2'd2, 8'h00, 8'h00, 1'b1, "R9 zero limit");
    chk(last_len == 1, "R9", "strobe low clocks at limit 0", last_len, 1);
    tmo_limit = 16'd40;
    dead = 1'b0;
    run_cmd(2'd2, 8'h00, 8'h00, 1'b0, "R9 read after recovery");
    run_cmd(2'd3, 8'h10, 8'h00, 1'b0, "R5 register read after recovery");

    repeat (5) @(negedge clk);
    chk(dir_viol == 0, "R6", "direction changes around strobe", dir_viol, 0);
    chk(ack_viol == 0, "R7", "strobe fell with acknowledge high", ack_viol, 0);
    chk(dual_viol == 0, "R7", "both strobes low", dual_viol, 0);
    chk(drive_viol == 0, "R11", "bus driven during read", drive_viol, 0);
    chk(pulse_viol == 0, "R10", "multi-cycle done", pulse_viol, 0);
    chk(stable_viol == 0, "R10", "response changed without done", stable_viol, 0);
    chk(orphan == 0, "R10", "unexpected done", orphan, 0);
    finish_sim();
  end
endmodule